// File: doc/BRIEF.md
# Pin Bank with Triggered Interrupts

A word-addressed general-purpose I/O bank of up to 32 pins. Each pin has a stored output value and an output-enable bit. Software sets both through a small register bus. Every pin input passes through a two-stage synchroniser, and the synchronised level can always be read back. Each pin can also be armed to raise an interrupt. Two independent bits pick its trigger: one chooses level or edge sensitivity, the other chooses polarity. Edge events are held in a latch until software acknowledges them. Level events follow the pin.

The interrupt path has, for each pin, an enable bit, a mask bit, a raw status bit and a masked status bit. A write-one-to-acknowledge register clears latched edges. One combined interrupt line goes to the processor, together with the index of the highest-numbered pending pin, which is the one software should service first.

The register bus is a request/response stream. A request (write flag, byte offset, write data) is taken on a cycle where `req_valid` and `req_ready` are both high. Every accepted request, read or write, returns exactly one response beat carrying the read data (zero for writes). The response is held on `rsp_rdata` with `rsp_valid` high until `rsp_ready` is seen high. While a response waits unaccepted, `req_ready` is low and no new request is taken: back-pressure on the response side stalls the request side.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every configuration register is zero, so `pin_oe` is all zero and `irq` is low. `rsp_valid` is low and `req_ready` is high.
- R2: Offset 0x00 holds the pin output values, which drive `pin_out`. Offset 0x04 holds the direction bits (1 = output, 0 = input), which drive `pin_oe`. Both read back what was written.
- R3: Offset 0x50 reads the synchronised level of every pin, whatever its direction. A change on `pin_in` appears there after two clock edges.
- R4: A pin whose trigger bits {polarity at 0x3C, kind at 0x38} are 00 is active-low level; 10 is active-high level. Its raw status follows the synchronised level, so a pin change shows on `irq` after two clock edges.
- R5: Trigger bits 01 select falling edge and 11 select rising edge. The event is latched: it shows on `irq` after three clock edges and stays set after the pin returns to its idle level.
- R6: Writing 1 to a bit of offset 0x4C clears that pin's latched edge. Bits written 0 are left alone, and level-triggered pins are unaffected.
- R7: If a new edge is detected in the same cycle as the acknowledge write for that pin, the edge wins and the status bit stays set.
- R8: Offset 0x30 holds the interrupt enables. A pin whose enable is 0 shows no raw status, and any edge it had latched is discarded. Writing zero to the register silences `irq`.
- R9: Offset 0x34 holds the mask bits. Raw status (0x44) ignores the mask. Masked status (0x40) equals raw AND NOT mask, and `irq` is the OR of the masked status.
- R10: While `irq` is high, `irq_pin` gives the highest pin index with masked status set. While `irq` is low, it is zero.
- R11: Exactly one response is returned per accepted request. While `rsp_valid` is high and `rsp_ready` is low, the response data holds steady, `req_ready` is low, and a pending write takes no effect.
- R12: Writes to the read-only offsets (0x40, 0x44, 0x50) are ignored. Unmapped offsets, and the acknowledge offset, read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response beat present |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| pin_in | input | NPINS | Asynchronous pin levels |
| pin_out | output | NPINS | Pin output values |
| pin_oe | output | NPINS | Pin output enables |
| irq | output | 1 | Combined interrupt |
| irq_pin | output | PIN_W | Highest pending pin index |

## Verification
A stuck or stale edge latch shows on the next read of the raw status, and on `irq`, within one cycle of the acknowledge that should have cleared it. An acknowledge that wrongly beats a same-cycle edge loses the event for good, so the bench lines up that race to the exact clock edge. A wrong trigger decode or an extra synchroniser stage shifts the arrival of `irq` by a whole cycle. The bench therefore samples the interrupt two cycles after a pin change for level triggers and three cycles after for edge triggers. A response-path fault shows as a changed `rsp_rdata`, or as an early write, while back-pressure is held.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] REG_OUTVAL    = 8'h00;
  localparam logic [ADDR_W-1:0] REG_OUTEN     = 8'h04;
  localparam logic [ADDR_W-1:0] REG_IRQ_EN    = 8'h30;
  localparam logic [ADDR_W-1:0] REG_IRQ_MASK  = 8'h34;
  localparam logic [ADDR_W-1:0] REG_TRIG_KIND = 8'h38;
  localparam logic [ADDR_W-1:0] REG_TRIG_POL  = 8'h3C;
  localparam logic [ADDR_W-1:0] REG_IRQ_PEND  = 8'h40;
  localparam logic [ADDR_W-1:0] REG_IRQ_RAW   = 8'h44;
  localparam logic [ADDR_W-1:0] REG_IRQ_ACK   = 8'h4C;
  localparam logic [ADDR_W-1:0] REG_PIN_LVL   = 8'h50;

  // {polarity, kind}
  typedef enum logic [1:0] {
    TRIG_LVL_LO    = 2'b00,
    TRIG_EDGE_FALL = 2'b01,
    TRIG_LVL_HI    = 2'b10,
    TRIG_EDGE_RISE = 2'b11
  } trig_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [NPINS-1:0]  outval,
  output logic [NPINS-1:0]  outen,
  output logic [NPINS-1:0]  irq_en,
  output logic [NPINS-1:0]  irq_mask,
  output logic [NPINS-1:0]  trig_kind,
  output logic [NPINS-1:0]  trig_pol,
  output logic [NPINS-1:0]  ack,
  input  logic [NPINS-1:0]  st_raw,
  input  logic [NPINS-1:0]  st_pend,
  input  logic [NPINS-1:0]  pin_lvl
);
  logic              take;
  logic              wr;
  logic [NPINS-1:0]  wbits;
  logic [NPINS-1:0]  rd_bits;
  logic [DATA_W-1:0] rd_word;

  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;
  assign wr        = take && req_write;
  assign wbits     = req_wdata[NPINS-1:0];
  assign ack       = (wr && req_addr == REG_IRQ_ACK) ? wbits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outval    <= '0;
      outen     <= '0;
      irq_en    <= '0;
      irq_mask  <= '0;
      trig_kind <= '0;
      trig_pol  <= '0;
    end else if (wr) begin
      case (req_addr)
        REG_OUTVAL:    outval    <= wbits;
        REG_OUTEN:     outen     <= wbits;
        REG_IRQ_EN:    irq_en    <= wbits;
        REG_IRQ_MASK:  irq_mask  <= wbits;
        REG_TRIG_KIND: trig_kind <= wbits;
        REG_TRIG_POL:  trig_pol  <= wbits;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (req_addr)
      REG_OUTVAL:    rd_bits = outval;
      REG_OUTEN:     rd_bits = outen;
      REG_IRQ_EN:    rd_bits = irq_en;
      REG_IRQ_MASK:  rd_bits = irq_mask;
      REG_TRIG_KIND: rd_bits = trig_kind;
      REG_TRIG_POL:  rd_bits = trig_pol;
      REG_IRQ_PEND:  rd_bits = st_pend;
      REG_IRQ_RAW:   rd_bits = st_raw;
      REG_PIN_LVL:   rd_bits = pin_lvl;
      default:       rd_bits = '0;
    endcase
    rd_word = '0;
    rd_word[NPINS-1:0] = rd_bits;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (take) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= req_write ? '0 : rd_word;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata)) else $error("response dropped"); // R11
  AST_STALL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> $stable(outval) && $stable(irq_en)) else $error("write during stall"); // R11
endmodule

// File: rtl/gpio_irq_engine.sv
module gpio_irq_engine
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 32,
  localparam int unsigned PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] lvl,
  input  logic [NPINS-1:0] irq_en,
  input  logic [NPINS-1:0] irq_mask,
  input  logic [NPINS-1:0] trig_kind,
  input  logic [NPINS-1:0] trig_pol,
  input  logic [NPINS-1:0] ack,
  output logic [NPINS-1:0] st_raw,
  output logic [NPINS-1:0] st_pend,
  output logic             irq,
  output logic [PIN_W-1:0] irq_pin
);
  logic [NPINS-1:0] lvl_d;
  logic [NPINS-1:0] edge_ev;
  logic [NPINS-1:0] held;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_d <= '0;
    else        lvl_d <= lvl;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    trig_e mode;
    logic  hit;
    logic  ev;
    logic  latch_q;

    assign mode = trig_e'({trig_pol[i], trig_kind[i]});

    always_comb begin
      hit = 1'b0;
      ev  = 1'b0;
      case (mode)
        TRIG_LVL_LO:    hit = !lvl[i];
        TRIG_LVL_HI:    hit = lvl[i];
        TRIG_EDGE_FALL: ev  = irq_en[i] && !lvl[i] && lvl_d[i];
        TRIG_EDGE_RISE: ev  = irq_en[i] && lvl[i] && !lvl_d[i];
        default: ;
      endcase
    end

    // A fresh edge is ORed in after the acknowledge, so it wins a tie.
    always_ff @(posedge clk) begin
      if (!rst_n) latch_q <= 1'b0;
      else        latch_q <= (latch_q && !ack[i] && irq_en[i] && trig_kind[i]) || ev;
    end

    assign edge_ev[i] = ev;
    assign held[i]    = latch_q;
    assign st_raw[i]  = irq_en[i] && (trig_kind[i] ? latch_q : hit);
  end

  assign st_pend = st_raw & ~irq_mask;
  assign irq     = |st_pend;

  always_comb begin
    irq_pin = '0;
    for (int k = 0; k < NPINS; k++) begin
      if (st_pend[k]) irq_pin = PIN_W'(k);
    end
  end

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    |(ack & ~edge_ev) |=> (held & $past(ack & ~edge_ev)) == '0) else $error("ack ignored"); // R6
  AST_EDGE_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    |edge_ev |=> (held & $past(edge_ev)) == $past(edge_ev)) else $error("edge lost"); // R7
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 32,
  localparam int unsigned PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq,
  output logic [PIN_W-1:0]  irq_pin
);
  logic [NPINS-1:0] lvl;
  logic [NPINS-1:0] irq_en;
  logic [NPINS-1:0] irq_mask;
  logic [NPINS-1:0] trig_kind;
  logic [NPINS-1:0] trig_pol;
  logic [NPINS-1:0] ack;
  logic [NPINS-1:0] st_raw;
  logic [NPINS-1:0] st_pend;

  gpio_sync #(.W(NPINS)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pin_in),
    .q    (lvl)
  );

  gpio_regfile #(.NPINS(NPINS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata),
    .outval   (pin_out),
    .outen    (pin_oe),
    .irq_en   (irq_en),
    .irq_mask (irq_mask),
    .trig_kind(trig_kind),
    .trig_pol (trig_pol),
    .ack      (ack),
    .st_raw   (st_raw),
    .st_pend  (st_pend),
    .pin_lvl  (lvl)
  );

  gpio_irq_engine #(.NPINS(NPINS)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl      (lvl),
    .irq_en   (irq_en),
    .irq_mask (irq_mask),
    .trig_kind(trig_kind),
    .trig_pol (trig_pol),
    .ack      (ack),
    .st_raw   (st_raw),
    .st_pend  (st_pend),
    .irq      (irq),
    .irq_pin  (irq_pin)
  );

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    irq_en == '0 |-> !irq) else $error("irq while disabled"); // R8
  AST_PIN_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> st_pend[irq_pin] && !irq_mask[irq_pin]) else $error("bad irq_pin"); // R10
  AST_PEND_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (st_pend & ~st_raw) == '0) else $error("pending without raw"); // R9
endmodule

// File: tb/gpio_irq_bank_bench.sv
module gpio_irq_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NPINS = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;
  logic        irq;
  logic [4:0]  irq_pin;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  gpio_irq_bank #(.NPINS(NPINS)) u_gpio_irq_bank (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq(irq), .irq_pin(irq_pin)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(bit w, logic [7:0] a, logic [31:0] d, output logic [31:0] r);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    r = rsp_rdata;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    logic [31:0] r;
    xfer(1'b1, a, d, r);
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] r);
    xfer(1'b0, a, '0, r);
  endtask

  task automatic cleanup();
    wr(8'h30, '0); wr(8'h34, '0); wr(8'h38, '0); wr(8'h3C, '0);
    @(negedge clk); pin_in = '0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] r;
    check("R1 pin_oe", pin_oe, '0);
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 rsp_valid", {31'b0, rsp_valid}, 0);
    check("R1 req_ready", {31'b0, req_ready}, 1);
    rd(8'h00, r); check("R1 outval", r, '0);
    rd(8'h30, r); check("R1 irq_en", r, '0);
  endtask

  task automatic t_outputs();
    logic [31:0] r;
    wr(8'h00, 32'hA5A5_3C3C);
    wr(8'h04, 32'h0000_FFFF);
    check("R2 pin_out", pin_out, 32'hA5A5_3C3C);
    check("R2 pin_oe", pin_oe, 32'h0000_FFFF);
    rd(8'h04, r); check("R2 dir readback", r, 32'h0000_FFFF);
  endtask

  task automatic t_pin_read();
    logic [31:0] r;
    @(negedge clk); pin_in = 32'h1234_5678;
    @(negedge clk);
    @(negedge clk);
    rd(8'h50, r); check("R3 pin level (mixed dir)", r, 32'h1234_5678);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h50, r); check("R3 pin level (all outputs)", r, 32'h1234_5678);
    cleanup();
  endtask

  task automatic t_level();
    logic [31:0] r;
    wr(8'h3C, 32'h0000_0008);
    wr(8'h30, 32'h0000_0008);
    check("R4 idle high-level", {31'b0, irq}, 0);
    @(negedge clk); pin_in[3] = 1'b1;
    @(negedge clk); check("R4 level after 1 edge", {31'b0, irq}, 0);
    @(negedge clk); check("R4 level after 2 edges", {31'b0, irq}, 1);
    @(negedge clk); pin_in[3] = 1'b0;
    repeat (2) @(negedge clk); check("R4 level follows pin", {31'b0, irq}, 0);
    wr(8'h30, 32'h0000_0018);
    rd(8'h44, r); check("R4 active-low raw", r, 32'h0000_0010);
    wr(8'h4C, 32'h0000_0010);
    rd(8'h44, r); check("R6 ack no effect on level", r, 32'h0000_0010);
    cleanup();
  endtask

  task automatic t_edge();
    logic [31:0] r;
    @(negedge clk); pin_in[9] = 1'b1;
    repeat (3) @(negedge clk);
    wr(8'h38, 32'h0000_0280);
    wr(8'h3C, 32'h0000_0080);
    wr(8'h30, 32'h0000_0280);
    check("R5 no spurious edge", {31'b0, irq}, 0);
    @(negedge clk); pin_in[7] = 1'b1;
    @(negedge clk);
    @(negedge clk); check("R5 rise after 2 edges", {31'b0, irq}, 0);
    @(negedge clk); check("R5 rise after 3 edges", {31'b0, irq}, 1);
    pin_in[7] = 1'b0;
    pin_in[9] = 1'b0;
    repeat (4) @(negedge clk);
    rd(8'h44, r); check("R5 latched rise and fall", r, 32'h0000_0280);
    wr(8'h4C, 32'h0000_0080);
    rd(8'h44, r); check("R6 ack clears only bit 7", r, 32'h0000_0200);
    wr(8'h4C, 32'h0000_0200);
    check("R6 irq after full ack", {31'b0, irq}, 0);
  endtask

  task automatic t_race();
    logic [31:0] r;
    @(negedge clk); pin_in[7] = 1'b1;
    repeat (4) @(negedge clk);
    pin_in[7] = 1'b0;
    repeat (4) @(negedge clk);
    pin_in[7] = 1'b1;
    @(negedge clk);
    wr(8'h4C, 32'h0000_0080);
    rd(8'h44, r); check("R7 edge wins over ack", r, 32'h0000_0080);
    wr(8'h4C, 32'h0000_0080);
    rd(8'h44, r); check("R7 later ack clears", r, 32'h0000_0000);
    cleanup();
  endtask

  task automatic t_mask_priority();
    logic [31:0] r;
    wr(8'h38, 32'h0000_0080);
    wr(8'h3C, 32'h0000_0088);
    wr(8'h30, 32'h0000_0088);
    @(negedge clk); pin_in[3] = 1'b1; pin_in[7] = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 highest pending", {27'b0, irq_pin}, 7);
    wr(8'h34, 32'h0000_0008);
    rd(8'h40, r); check("R9 masked status", r, 32'h0000_0080);
    rd(8'h44, r); check("R9 raw ignores mask", r, 32'h0000_0088);
    wr(8'h34, 32'h0000_0088);
    check("R9 irq all masked", {31'b0, irq}, 0);
    check("R10 idle index", {27'b0, irq_pin}, 0);
    wr(8'h34, 32'h0000_0000);
    wr(8'h4C, 32'h0000_0080);
    check("R10 next pending", {27'b0, irq_pin}, 3);
    wr(8'h4C, 32'h0000_0000);
    @(negedge clk); pin_in[7] = 1'b0;
    repeat (3) @(negedge clk); pin_in[7] = 1'b1;
    repeat (4) @(negedge clk);
    wr(8'h30, 32'h0000_0000);
    check("R8 irq off when disabled", {31'b0, irq}, 0);
    rd(8'h44, r); check("R8 raw off when disabled", r, 32'h0);
    wr(8'h30, 32'h0000_0080);
    rd(8'h44, r); check("R8 latch discarded", r, 32'h0);
    cleanup();
  endtask

  task automatic t_backpressure();
    logic [31:0] r;
    wr(8'h00, 32'h0000_1111);
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h00;
    @(negedge clk);
    check("R11 response present", {31'b0, rsp_valid}, 1);
    check("R11 stall ready", {31'b0, req_ready}, 0);
    req_write = 1'b1; req_wdata = 32'h0000_2222;
    repeat (3) @(negedge clk);
    check("R11 data held", rsp_rdata, 32'h0000_1111);
    check("R11 write not taken", pin_out, 32'h0000_1111);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R11 write taken after release", pin_out, 32'h0000_2222);
    @(negedge clk);
    check("R11 single response", {31'b0, rsp_valid}, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] r;
    rd(8'h20, r); check("R12 unmapped reads zero", r, '0);
    rd(8'h4C, r); check("R12 ack reads zero", r, '0);
    wr(8'h44, 32'hFFFF_FFFF);
    wr(8'h50, 32'hFFFF_FFFF);
    rd(8'h44, r); check("R12 raw write ignored", r, '0);
    rd(8'h50, r); check("R12 level write ignored", r, '0);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_outputs();
    t_pin_read();
    t_level();
    t_edge();
    t_race();
    t_mask_priority();
    t_backpressure();
    t_unmapped();
    done = 1;
    finish_run();
  end
endmodule